// File: doc/BRIEF.md
# Segment Register Load Unit

This block loads a segment register's cached descriptor from a 16-bit selector. It runs one of two paths. In protected operation it first compares the selector's table offset with the descriptor table limit. It then reads the 8-byte descriptor as two 32-bit words through a request/acknowledge memory port. Next it applies the access rules for the chosen target, which is either a stack segment or a data segment. When a load succeeds, the base, limit and attribute bits are unpacked into the cache. In real-address operation, or while virtual-8086 operation is active, no memory is touched and the base is simply the selector times sixteen.

A load starts with a one-cycle `load_start` strobe while the unit is idle. It ends with a one-cycle `done` pulse together with a fault code. A faulting load leaves the cached descriptor exactly as it was. Code-segment loads are not handled here.

Top module: `seg_load_unit`

## Requirements
- R1: After reset, `done`, `fault_code` and `mem_req` are 0, and every cache output (`c_sel`, `c_base`, `c_limit`, `c_flags`) is 0.
- R2: Real-address path when `prot_en` is 0 or `v86_mode` is 1.
  - No memory request is made.
  - `done` rises in the cycle after the strobe, with fault code 0.
  - `c_sel` takes the selector and `c_base` becomes selector << 4.
  - `c_limit` and `c_flags` keep their values.
- R3: On the protected path, the table offset is the selector with bits [2:0] cleared. If that offset is greater than `tbl_limit`, the load ends with fault code 1 (general protection) and no memory request is made.
- R4: Descriptor fetch.
  - The low word is read from `tbl_base` + offset, then the high word from `tbl_base` + offset + 4.
  - Each request stays high with a steady address until acknowledged.
  - Exactly two reads are made per in-bounds protected load.
- R5: A stack load gives fault code 1 if any of these holds:
  - the selector index (bits [15:3]) is zero;
  - the S bit is 0;
  - the descriptor is executable;
  - the descriptor is not writable;
  - the RPL (selector bits [1:0]) differs from `cur_cpl`;
  - the RPL differs from the descriptor DPL.
- R6: A stack load that passes every R5 rule but has its present bit clear gives fault code 2 (stack fault). The R5 rules take priority.
- R7: A data load gives fault code 1 if the S bit is 0, or if both RPL and `cur_cpl` are numerically greater than DPL.
- R8: A data load that passes R7 but has its present bit clear gives fault code 3 (not present). The R7 rules take priority.
- R9: Base and limit assembly from the descriptor.
  - Low word: limit[15:0] in bits [15:0], base[15:0] in bits [31:16].
  - High word: base[23:16] in [7:0], type in [11:8], S in 12, DPL in [14:13], present in 15, limit[19:16] in [19:16], default size in 22, granularity in 23, base[31:24] in [31:24].
  - A successful load sets `c_base` to the 32-bit base and `c_limit` to the 20-bit limit, zero-extended.
- R10: When the granularity bit is 1, `c_limit` is the 20-bit limit shifted left by 12, with zeros filled in below.
- R11: A successful protected load sets `c_sel` to the selector. It sets `c_flags` as follows:
  - [0] accessed, [1] read/write, [2] direction/conforming, [3] executable (type bits 8..11);
  - [4] S;
  - [6:5] DPL;
  - [7] present;
  - [8] default size.
- R12: Every load produces exactly one one-cycle `done` pulse carrying one fault code. On any nonzero fault code, all four cache outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_start | input | 1 | Starts a load when the unit is idle |
| load_sel | input | 16 | Selector to load |
| load_stack | input | 1 | 1 = stack segment target, 0 = data segment target |
| cur_cpl | input | 2 | Current privilege level |
| prot_en | input | 1 | Protection enable |
| v86_mode | input | 1 | Virtual-8086 operation active |
| tbl_base | input | 32 | Descriptor table base address |
| tbl_limit | input | 16 | Descriptor table limit (last valid byte offset) |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_ack | input | 1 | Read acknowledge; data valid in the same cycle |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle completion pulse |
| fault_code | output | 2 | 0 none, 1 general protection, 2 stack fault, 3 not present |
| c_sel | output | 16 | Cached selector |
| c_base | output | 32 | Cached base |
| c_limit | output | 32 | Cached limit after granularity scaling |
| c_flags | output | 9 | Cached attribute bits, layout per R11 |

## Verification
The bench uses the default parameters: a granularity shift of 12 and a real-address shift of 4. This places page-scaled limits such as 0xF000 and paragraph bases such as 0x12340 at exact, known values. A responder acknowledges every other cycle, so each fetch holds its request across a wait cycle. The eight-entry table mixes descriptors so that each fault rule fires while the other rules pass. It also includes descriptors that break two rules at once, which checks the fault priority. The table limit is moved to just below and exactly at an entry's offset to test the bounds comparison at its edge.

// File: rtl/seg_load_pkg.sv
package seg_load_pkg;

    localparam int SEL_W   = 16;
    localparam int ADDR_W  = 32;
    localparam int WORD_W  = 32;
    localparam int LIM20_W = 20;
    localparam int FLAG_W  = 9;
    localparam int STEP_B  = 4;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_GP    = 2'd1,
        FLT_STACK = 2'd2,
        FLT_NP    = 2'd3
    } fault_e;

    typedef struct packed {
        logic       dsize;
        logic       present;
        logic [1:0] dpl;
        logic       s_bit;
        logic       exec;
        logic       dir_conf;
        logic       rw;
        logic       accessed;
    } seg_flags_t;

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] limit;
        seg_flags_t        flags;
    } seg_cache_t;

    function automatic logic [SEL_W-1:0] sel_offset(input logic [SEL_W-1:0] s);
        return {s[SEL_W-1:3], 3'b000};
    endfunction

    function automatic logic [1:0] sel_rpl(input logic [SEL_W-1:0] s);
        return s[1:0];
    endfunction

endpackage

// File: rtl/seg_desc_fetch.sv
module seg_desc_fetch
    import seg_load_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [ADDR_W-1:0] start_addr,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              words_vld,
    output logic [WORD_W-1:0] w_lo,
    output logic [WORD_W-1:0] w_hi
);
    typedef enum logic [1:0] {F_IDLE, F_LO, F_HI} fst_e;
    fst_e fst;

    always_ff @(posedge clk) begin
        if (rst) begin
            fst       <= F_IDLE;
            mem_addr  <= '0;
            w_lo      <= '0;
            w_hi      <= '0;
            words_vld <= 1'b0;
        end else begin
            words_vld <= 1'b0;
            unique case (fst)
                F_IDLE: if (go) begin
                    mem_addr <= start_addr;
                    fst      <= F_LO;
                end
                F_LO: if (mem_ack) begin
                    w_lo     <= mem_rdata;
                    mem_addr <= mem_addr + ADDR_W'(STEP_B);
                    fst      <= F_HI;
                end
                F_HI: if (mem_ack) begin
                    w_hi      <= mem_rdata;
                    words_vld <= 1'b1;
                    fst       <= F_IDLE;
                end
                default: fst <= F_IDLE;
            endcase
        end
    end

    assign mem_req = (fst != F_IDLE);
endmodule

// File: rtl/seg_desc_unpack.sv
module seg_desc_unpack
    import seg_load_pkg::*;
#(
    parameter int GRAN_SHIFT = 12
) (
    input  logic [WORD_W-1:0] w_lo,
    input  logic [WORD_W-1:0] w_hi,
    output logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] limit,
    output seg_flags_t        flags
);
    logic [LIM20_W-1:0] lim20;
    logic               gran;
    logic               unused_hi_bits;

    assign base  = {w_hi[31:24], w_hi[7:0], w_lo[31:16]};
    assign lim20 = {w_hi[19:16], w_lo[15:0]};
    assign gran  = w_hi[23];

    always_comb begin
        if (gran) limit = ADDR_W'(lim20) << GRAN_SHIFT;
        else      limit = ADDR_W'(lim20);
    end

    always_comb begin
        flags.accessed = w_hi[8];
        flags.rw       = w_hi[9];
        flags.dir_conf = w_hi[10];
        flags.exec     = w_hi[11];
        flags.s_bit    = w_hi[12];
        flags.dpl      = w_hi[14:13];
        flags.present  = w_hi[15];
        flags.dsize    = w_hi[22];
    end

    assign unused_hi_bits = ^w_hi[21:20];
endmodule

// File: rtl/seg_rule_check.sv
module seg_rule_check
    import seg_load_pkg::*;
(
    input  logic             is_stack,
    input  logic [SEL_W-1:0] sel,
    input  logic [1:0]       cpl,
    input  seg_flags_t       flags,
    output fault_e           fault
);
    logic [1:0] rpl;
    logic       null_sel;
    logic       stk_gp;
    logic       dat_gp;
    logic       unused_flag_bits;

    assign rpl      = sel_rpl(sel);
    assign null_sel = (sel[SEL_W-1:3] == '0);

    assign stk_gp = null_sel || !flags.s_bit || flags.exec || !flags.rw ||
                    (rpl != cpl) || (rpl != flags.dpl);
    assign dat_gp = !flags.s_bit || ((rpl > flags.dpl) && (cpl > flags.dpl));

    always_comb begin
        if (is_stack) begin
            if (stk_gp)              fault = FLT_GP;
            else if (!flags.present) fault = FLT_STACK;
            else                     fault = FLT_NONE;
        end else begin
            if (dat_gp)              fault = FLT_GP;
            else if (!flags.present) fault = FLT_NP;
            else                     fault = FLT_NONE;
        end
    end

    assign unused_flag_bits = flags.dsize ^ flags.dir_conf ^ flags.accessed;
endmodule

// File: rtl/seg_load_unit.sv
module seg_load_unit
    import seg_load_pkg::*;
#(
    parameter int GRAN_SHIFT = 12,
    parameter int REAL_SHIFT = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        load_start,
    input  logic [15:0] load_sel,
    input  logic        load_stack,
    input  logic [1:0]  cur_cpl,
    input  logic        prot_en,
    input  logic        v86_mode,
    input  logic [31:0] tbl_base,
    input  logic [15:0] tbl_limit,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic        done,
    output logic [1:0]  fault_code,
    output logic [15:0] c_sel,
    output logic [31:0] c_base,
    output logic [31:0] c_limit,
    output logic [8:0]  c_flags
);
    seg_cache_t        cache_q;
    fault_e            fault_q;
    fault_e            rule_fault;
    logic              busy;
    logic [SEL_W-1:0]  sel_q;
    logic              stack_q;
    logic [1:0]        cpl_q;
    logic              real_path;
    logic              in_bounds;
    logic              fetch_go;
    logic [ADDR_W-1:0] fetch_addr;
    logic              words_vld;
    logic [WORD_W-1:0] w_lo;
    logic [WORD_W-1:0] w_hi;
    logic [ADDR_W-1:0] dec_base;
    logic [ADDR_W-1:0] dec_limit;
    seg_flags_t        dec_flags;

    assign real_path  = !prot_en || v86_mode;
    assign in_bounds  = (sel_offset(load_sel) <= tbl_limit);
    assign fetch_go   = !busy && load_start && !real_path && in_bounds;
    assign fetch_addr = tbl_base + ADDR_W'(sel_offset(load_sel));

    seg_desc_fetch u_fetch (
        .clk       (clk),
        .rst       (rst),
        .go        (fetch_go),
        .start_addr(fetch_addr),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .words_vld (words_vld),
        .w_lo      (w_lo),
        .w_hi      (w_hi)
    );

    seg_desc_unpack #(.GRAN_SHIFT(GRAN_SHIFT)) u_unpack (
        .w_lo (w_lo),
        .w_hi (w_hi),
        .base (dec_base),
        .limit(dec_limit),
        .flags(dec_flags)
    );

    seg_rule_check u_rules (
        .is_stack(stack_q),
        .sel     (sel_q),
        .cpl     (cpl_q),
        .flags   (dec_flags),
        .fault   (rule_fault)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cache_q <= '0;
            fault_q <= FLT_NONE;
            done    <= 1'b0;
            busy    <= 1'b0;
            sel_q   <= '0;
            stack_q <= 1'b0;
            cpl_q   <= '0;
        end else begin
            done <= 1'b0;
            if (!busy && load_start) begin
                if (real_path) begin
                    cache_q.sel  <= load_sel;
                    cache_q.base <= ADDR_W'(load_sel) << REAL_SHIFT;
                    fault_q      <= FLT_NONE;
                    done         <= 1'b1;
                end else if (!in_bounds) begin
                    fault_q <= FLT_GP;
                    done    <= 1'b1;
                end else begin
                    busy    <= 1'b1;
                    sel_q   <= load_sel;
                    stack_q <= load_stack;
                    cpl_q   <= cur_cpl;
                end
            end else if (busy && words_vld) begin
                busy    <= 1'b0;
                done    <= 1'b1;
                fault_q <= rule_fault;
                if (rule_fault == FLT_NONE) begin
                    cache_q.sel   <= sel_q;
                    cache_q.base  <= dec_base;
                    cache_q.limit <= dec_limit;
                    cache_q.flags <= dec_flags;
                end
            end
        end
    end

    assign fault_code = fault_q;
    assign c_sel      = cache_q.sel;
    assign c_base     = cache_q.base;
    assign c_limit    = cache_q.limit;
    assign c_flags    = cache_q.flags;
endmodule

// File: rtl/seg_load_chk.sv
module seg_load_chk (
    input logic        clk,
    input logic        rst,
    input logic        mem_req,
    input logic        mem_ack,
    input logic [31:0] mem_addr,
    input logic        done,
    input logic [1:0]  fault_code,
    input logic [15:0] c_sel,
    input logic [31:0] c_base,
    input logic [31:0] c_limit,
    input logic [8:0]  c_flags
);
    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R12
    fault_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (done && fault_code != 2'd0) |->
            ($stable(c_sel) && $stable(c_base) && $stable(c_limit) && $stable(c_flags)));

    // R4
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_req);
endmodule

bind seg_load_unit seg_load_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_req   (mem_req),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .done      (done),
    .fault_code(fault_code),
    .c_sel     (c_sel),
    .c_base    (c_base),
    .c_limit   (c_limit),
    .c_flags   (c_flags)
);

// File: tb/tb_seg_load_unit.sv
module tb_seg_load_unit;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] TBASE = 32'h0001_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_start = 1'b0;
    logic [15:0] load_sel = '0;
    logic        load_stack = 1'b0;
    logic [1:0]  cur_cpl = '0;
    logic        prot_en = 1'b0;
    logic        v86_mode = 1'b0;
    logic [31:0] tbl_base = TBASE;
    logic [15:0] tbl_limit = 16'h003F;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata;
    logic        done;
    logic [1:0]  fault_code;
    logic [15:0] c_sel;
    logic [31:0] c_base;
    logic [31:0] c_limit;
    logic [8:0]  c_flags;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [31:0] d_lo [8];
    logic [31:0] d_hi [8];
    logic [31:0] addr_log [128];
    int          nreads = 0;

    logic [15:0] e_sel = '0;
    logic [31:0] e_base = '0;
    logic [31:0] e_limit = '0;
    logic [8:0]  e_flags = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_load_unit dut (
        .clk(clk), .rst(rst), .load_start(load_start), .load_sel(load_sel),
        .load_stack(load_stack), .cur_cpl(cur_cpl), .prot_en(prot_en),
        .v86_mode(v86_mode), .tbl_base(tbl_base), .tbl_limit(tbl_limit),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .done(done), .fault_code(fault_code),
        .c_sel(c_sel), .c_base(c_base), .c_limit(c_limit), .c_flags(c_flags)
    );

    // memory responder: acknowledges every other cycle
    always_comb begin
        logic [31:0] off;
        off = mem_addr - TBASE;
        if (off < 32'd64) mem_rdata = off[2] ? d_hi[off[5:3]] : d_lo[off[5:3]];
        else              mem_rdata = 32'hDEAD_BEEF;
    end

    always @(negedge clk) begin
        if (rst) mem_ack <= 1'b0;
        else     mem_ack <= mem_req && !mem_ack;
    end

    always @(posedge clk) begin
        if (!rst && mem_req && mem_ack) begin
            addr_log[nreads & 127] <= mem_addr;
            nreads <= nreads + 1;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic put_desc(input int idx, input logic [31:0] base, input logic [19:0] lim,
                            input logic [3:0] typ, input logic s, input logic [1:0] dpl,
                            input logic p, input logic d, input logic g);
        d_lo[idx] = {base[15:0], lim[15:0]};
        d_hi[idx] = {base[31:24], g, d, 2'b00, lim[19:16], p, dpl, s, typ, base[23:16]};
    endtask

    task automatic run_load(input string req, input logic [15:0] sel, input logic stk,
                            input logic [1:0] cpl, input logic pe, input logic v86,
                            input logic [1:0] exp_fault, input int exp_reads);
        int r0;
        int waitc;
        r0 = nreads;
        @(negedge clk);
        load_start = 1'b1; load_sel = sel; load_stack = stk;
        cur_cpl = cpl; prot_en = pe; v86_mode = v86;
        @(negedge clk);
        load_start = 1'b0;
        waitc = 0;
        while (!done && waitc < 50) begin
            @(negedge clk);
            waitc++;
        end
        check({req, " done"}, 64'(done), 64'd1);
        check({req, " fault"}, 64'(fault_code), 64'(exp_fault));
        check({req, " reads"}, 64'(nreads - r0), 64'(exp_reads));
        if (exp_reads == 2) begin
            check("R4 first address", 64'(addr_log[r0 & 127]), 64'(TBASE + {16'd0, sel[15:3], 3'b000}));
            check("R4 second address", 64'(addr_log[(r0 + 1) & 127]), 64'(TBASE + {16'd0, sel[15:3], 3'b000} + 32'd4));
        end
        check({req, " c_sel"}, 64'(c_sel), 64'(e_sel));
        check({req, " c_base"}, 64'(c_base), 64'(e_base));
        check({req, " c_limit"}, 64'(c_limit), 64'(e_limit));
        check({req, " c_flags"}, 64'(c_flags), 64'(e_flags));
        @(negedge clk);
        check({req, " done pulse"}, 64'(done), 64'd0);
    endtask

    task automatic expect_ok(input int idx, input logic [15:0] sel, input logic [31:0] lim_exp);
        e_sel   = sel;
        e_base  = {d_hi[idx][31:24], d_hi[idx][7:0], d_lo[idx][31:16]};
        e_limit = lim_exp;
        e_flags = {d_hi[idx][22], d_hi[idx][15], d_hi[idx][14:13], d_hi[idx][12], d_hi[idx][11:8]};
    endtask

    task automatic t_reset;
        check("R1 done", 64'(done), 64'd0);
        check("R1 fault", 64'(fault_code), 64'd0);
        check("R1 mem_req", 64'(mem_req), 64'd0);
        check("R1 cache", {c_sel, c_base[15:0], c_limit[15:0], 7'd0, c_flags}, 64'd0);
        check("R1 cache hi", {32'd0, c_base[31:16], c_limit[31:16]}, 64'd0);
    endtask

    task automatic t_real;
        e_sel = 16'h1234; e_base = 32'h0001_2340;
        run_load("R2 real", 16'h1234, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 0);
        e_sel = 16'hFFFB; e_base = 32'h000F_FFB0;
        run_load("R2 v86", 16'hFFFB, 1'b1, 2'd3, 1'b1, 1'b1, 2'd0, 0);
    endtask

    task automatic t_data_ok;
        expect_ok(1, 16'h000B, 32'h000A_BCDE);
        run_load("R9 data ok", 16'h000B, 1'b0, 2'd3, 1'b1, 1'b0, 2'd0, 2);
        expect_ok(2, 16'h0010, 32'h0000_F000);
        run_load("R10 gran", 16'h0010, 1'b0, 2'd0, 1'b1, 1'b0, 2'd0, 2);
        // after a real load, protected load replaces all fields (R11)
        e_sel = 16'h0100; e_base = 32'h0000_1000;
        run_load("R2 keep limit", 16'h0100, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 0);
        expect_ok(4, 16'h0020, 32'h0000_1234);
        run_load("R11 data dpl0 cpl3 rpl0", 16'h0020, 1'b0, 2'd3, 1'b1, 1'b0, 2'd0, 2);
        expect_ok(4, 16'h0023, 32'h0000_1234);
        run_load("R7 rpl3 cpl0 ok", 16'h0023, 1'b0, 2'd0, 1'b1, 1'b0, 2'd0, 2);
    endtask

    task automatic t_bounds;
        tbl_limit = 16'h0037;
        run_load("R3 beyond", 16'h003B, 1'b0, 2'd0, 1'b1, 1'b0, 2'd1, 0);
        tbl_limit = 16'h0038;
        expect_ok(7, 16'h003B, 32'h0000_0FFF);
        run_load("R3 at limit", 16'h003B, 1'b0, 2'd0, 1'b1, 1'b0, 2'd0, 2);
        tbl_limit = 16'h003F;
        run_load("R3 far", 16'h0040, 1'b1, 2'd0, 1'b1, 1'b0, 2'd1, 0);
    endtask

    task automatic t_data_faults;
        run_load("R7 system", 16'h001B, 1'b0, 2'd3, 1'b1, 1'b0, 2'd1, 2);
        run_load("R7 priv", 16'h0023, 1'b0, 2'd3, 1'b1, 1'b0, 2'd1, 2);
        run_load("R8 not present", 16'h002B, 1'b0, 2'd3, 1'b1, 1'b0, 2'd3, 2);
    endtask

    task automatic t_stack;
        run_load("R5 null", 16'h0000, 1'b1, 2'd0, 1'b1, 1'b0, 2'd1, 2);
        run_load("R5 exec", 16'h0030, 1'b1, 2'd0, 1'b1, 1'b0, 2'd1, 2);
        run_load("R5 readonly", 16'h0038, 1'b1, 2'd0, 1'b1, 1'b0, 2'd1, 2);
        run_load("R5 rpl ne cpl", 16'h0020, 1'b1, 2'd1, 1'b1, 1'b0, 2'd1, 2);
        run_load("R5 rpl ne dpl", 16'h0023, 1'b1, 2'd3, 1'b1, 1'b0, 2'd1, 2);
        run_load("R5 system", 16'h001B, 1'b1, 2'd3, 1'b1, 1'b0, 2'd1, 2);
        run_load("R6 not present", 16'h002B, 1'b1, 2'd3, 1'b1, 1'b0, 2'd2, 2);
        expect_ok(4, 16'h0020, 32'h0000_1234);
        run_load("R12 stack ok", 16'h0020, 1'b1, 2'd0, 1'b1, 1'b0, 2'd0, 2);
    endtask

    initial begin
        // e0 valid writable data, dpl0: only the null rule rejects it as stack
        put_desc(0, 32'h0000_0000, 20'hFFFFF, 4'b0010, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0);
        put_desc(1, 32'h1234_5678, 20'hABCDE, 4'b0011, 1'b1, 2'd3, 1'b1, 1'b1, 1'b0);
        put_desc(2, 32'h0040_0000, 20'h0000F, 4'b0110, 1'b1, 2'd0, 1'b1, 1'b0, 1'b1);
        put_desc(3, 32'h0000_0800, 20'h00067, 4'b1001, 1'b0, 2'd3, 1'b0, 1'b0, 1'b0);
        put_desc(4, 32'h00AB_CDEF, 20'h01234, 4'b0010, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0);
        put_desc(5, 32'h0000_2000, 20'h00FFF, 4'b0010, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0);
        put_desc(6, 32'h0000_3000, 20'h00FFF, 4'b1010, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0);
        put_desc(7, 32'h5500_4000, 20'h00FFF, 4'b0000, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_real();
        t_data_ok();
        t_bounds();
        t_data_faults();
        t_stack();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule